// File: doc/BRIEF.md
# Programmable Third-Order Decimator

This block turns the one-bit output of a sigma-delta modulator into 15-bit two's complement samples. The filter is a third-order cascaded integrator-comb structure, with response ((1 - z^-N)/(1 - z^-1))^3. A two-bit select picks the decimation ratio N from 32, 64, 128 and 256. The integrators run on every modulator strobe. The combs run once every N strobes.

Each input bit stands for +1 or -1. The comb result is shifted right by an amount that depends on the ratio, so that a steady all-ones or all-zeros stream gives the same full-scale code at every ratio. The sample is also offered as a 16-bit transfer word. The top bit of that word is a control/data flag, and it is zero for data.

When the rate select changes, all filter state is flushed. The next three decimated results are then withheld, because the filter window still reaches back into the flushed history.

Top module: `sinc3_decim`

## Requirements
- R1: After reset, `sample_o` and `word_o` are zero and `valid_o` is low.
- R2: Input bit 1 counts as +1 and bit 0 counts as -1. A settled all-ones stream gives `sample_o` = 0x3FFF, because +full scale saturates. A settled all-zeros stream gives 0x4000 (-16384).
- R3: The output is linear in the density of ones. A settled repeating pattern with three ones in every four bits gives 0x2000 (+8192). A pattern with one one in every four bits gives 0x6000 (-8192).
- R4: A settled alternating 1/0 stream gives exactly 0.
- R5: `rate_sel_i` values 0, 1, 2 and 3 select N = 32, 64, 128 and 256. After a flush, the k-th valid result (k = 0, 1, ...) follows the (4+k)·N-th strobe and appears in the cycle after that strobe's clock edge.
- R6: A reset, or any change of `rate_sel_i`, clears the integrator, comb and ratio counter state. No valid result is produced for the next 3·N strobes.
- R7: `word_o[15]` is 0 (the data flag) and `word_o[14:0]` equals `sample_o`.
- R8: Bits presented while `mod_stb_i` is low have no effect on any result.
- R9: `valid_o` is high for exactly one cycle per result. `sample_o` holds its value between results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_stb_i | input | 1 | One-cycle strobe at the modulator bit rate |
| mod_bit_i | input | 1 | Modulator bit, sampled when the strobe is high |
| rate_sel_i | input | 2 | Ratio select: 0 gives N=32, 1 gives 64, 2 gives 128, 3 gives 256 |
| sample_o | output | 15 | Decimated two's complement sample |
| valid_o | output | 1 | One-cycle pulse when a new sample is available |
| word_o | output | 16 | Transfer word: flag bit 15 (0 = data), sample in bits 14:0 |

## Verification
The hardest situation to reach is the first result after a flush. The exact value depends on the window lining up with the cleared history, and on the withheld results being counted correctly. Each case changes the rate select, so the test passes through a flush every time, and some changes arrive partway through a decimation period. The stimulus patterns repeat every four bits. For every ratio, each settled window then sums to a known constant whatever its phase, so the bench can predict exact codes without modelling the pipeline. Garbage bits are driven between strobes throughout the run.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int unsigned CIC_ORDER = 3;
  localparam int unsigned WARMUP    = 3;

  typedef enum logic [1:0] {
    RATE_R32  = 2'd0,
    RATE_R64  = 2'd1,
    RATE_R128 = 2'd2,
    RATE_R256 = 2'd3
  } rate_e;

  // right shift that maps N^3 full scale onto the output sign boundary
  function automatic int scale_shift(input int lg, input int out_w);
    return int'(CIC_ORDER) * lg - (out_w - 1);
  endfunction
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int unsigned W = 26
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (en_i)   acc_q <= acc_q + d_i;  // modular wrap intended
  end

  assign q_o = acc_q;
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int unsigned W = 26
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dly_q <= '0;
    else if (clr_i)  dly_q <= '0;
    else if (en_i)   dly_q <= d_i;
  end

  assign q_o = d_i - dly_q;
endmodule

// File: rtl/sinc3_ratio_ctr.sv
module sinc3_ratio_ctr #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned LOG_W  = 4,
  parameter int unsigned WARM_N = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             stb_i,
  input  logic [LOG_W-1:0] lg_i,
  output logic             tick_o,
  output logic             ready_o
);
  localparam int unsigned WARM_W = $clog2(WARM_N + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    lim;
  logic [WARM_W-1:0] warm_q;

  assign lim     = ((CNT_W+1)'(1) << lg_i) - (CNT_W+1)'(1);
  assign tick_o  = stb_i && !clr_i && ({1'b0, cnt_q} == lim);
  assign ready_o = (warm_q == WARM_W'(WARM_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      warm_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      warm_q <= '0;
    end else if (stb_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
      if (tick_o && !ready_o) warm_q <= warm_q + WARM_W'(1);
    end
  end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int unsigned OUT_W   = 15,
  parameter int unsigned MIN_LOG = 5,
  parameter int unsigned MAX_LOG = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mod_stb_i,
  input  logic             mod_bit_i,
  input  logic [1:0]       rate_sel_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o,
  output logic [OUT_W:0]   word_o
);
  localparam int unsigned ACC_W = CIC_ORDER * MAX_LOG + 2;
  localparam int unsigned LOG_W = $clog2(MAX_LOG + 1);
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM - ACC_W'(1);

  rate_e            rate_q;
  logic             chg;
  logic [LOG_W-1:0] lg;
  logic [ACC_W-1:0] x;
  logic             tick, ready;

  logic [CIC_ORDER:0][ACC_W-1:0] int_d;
  logic [CIC_ORDER:0][ACC_W-1:0] cmb_d;

  logic signed [ACC_W-1:0] diff, scaled;
  logic [OUT_W-1:0]        sat;
  logic [OUT_W-1:0]        sample_q;
  logic                    valid_q;

  assign chg = (rate_sel_i != rate_q);
  assign lg  = LOG_W'(MIN_LOG) + LOG_W'(rate_q);
  assign x   = mod_bit_i ? ACC_W'(1) : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rate_q <= RATE_R32;
    else         rate_q <= rate_e'(rate_sel_i);
  end

  assign int_d[0] = x;
  for (genvar g = 0; g < CIC_ORDER; g++) begin : g_int
    sinc3_integ #(.W(ACC_W)) u_integ (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (chg),
      .en_i  (mod_stb_i),
      .d_i   (int_d[g]),
      .q_o   (int_d[g+1])
    );
  end

  sinc3_ratio_ctr #(
    .CNT_W (MAX_LOG),
    .LOG_W (LOG_W),
    .WARM_N(WARMUP)
  ) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (chg),
    .stb_i  (mod_stb_i),
    .lg_i   (lg),
    .tick_o (tick),
    .ready_o(ready)
  );

  assign cmb_d[0] = int_d[CIC_ORDER];
  for (genvar g = 0; g < CIC_ORDER; g++) begin : g_comb
    sinc3_comb #(.W(ACC_W)) u_comb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (chg),
      .en_i  (tick),
      .d_i   (cmb_d[g]),
      .q_o   (cmb_d[g+1])
    );
  end

  always_comb begin
    diff   = cmb_d[CIC_ORDER];
    scaled = diff >>> scale_shift(int'(lg), OUT_W);
    if (scaled > POS_LIM)      sat = POS_LIM[OUT_W-1:0];
    else if (scaled < NEG_LIM) sat = NEG_LIM[OUT_W-1:0];
    else                       sat = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= tick && ready;
      if (tick && ready) sample_q <= sat;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
  assign word_o   = {1'b0, sample_q};  // flag 0 marks a data word
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int unsigned OUT_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mod_stb_i,
  input logic [1:0]       rate_sel_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] sample_o
);
  assert_valid_after_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(mod_stb_i));

  assert_no_valid_after_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_i != $past(rate_sel_i)) |=> !valid_o);

  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_sample_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o));
endmodule

bind sinc3_decim sinc3_decim_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mod_stb_i (mod_stb_i),
  .rate_sel_i(rate_sel_i),
  .valid_o   (valid_o),
  .sample_o  (sample_o)
);

// File: tb/tb_sinc3_decim.sv
module tb_sinc3_decim;
  localparam int CLK_PERIOD = 10;
  localparam int STB_DIV    = 4;
  localparam int WATCHDOG   = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mod_stb_i = 1'b0;
  logic        mod_bit_i = 1'b0;
  logic [1:0]  rate_sel_i = 2'd0;
  logic [14:0] sample_o;
  logic        valid_o;
  logic [15:0] word_o;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  int out_idx = 0;
  int cur_n = 32;
  int pat_idx = 0;
  logic prev_valid = 1'b0;

  logic [14:0] exp_q[$];
  string       tag_q[$];

  sinc3_decim dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mod_stb_i(mod_stb_i), .mod_bit_i(mod_bit_i),
    .rate_sel_i(rate_sel_i), .sample_o(sample_o), .valid_o(valid_o), .word_o(word_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one strobe; garbage on the bit line between strobes exercises R8
  task automatic strobe(input logic [3:0] pat);
    @(negedge clk_i);
    mod_stb_i = 1'b1;
    mod_bit_i = pat[pat_idx % 4];
    pat_idx++;
    stb_cnt++;
    @(negedge clk_i);
    mod_stb_i = 1'b0;
    mod_bit_i = ~mod_bit_i;
    repeat (STB_DIV - 2) @(negedge clk_i);
  endtask

  task automatic run_case(input logic [1:0] sel, input logic [3:0] pat,
                          input logic [14:0] expv, input string tag, input int k);
    @(negedge clk_i);
    rate_sel_i = sel;
    stb_cnt = 0;
    out_idx = 0;
    cur_n = 32 << sel;
    repeat (3 * cur_n) strobe(pat);  // R6: no results expected here
    for (int i = 0; i < k; i++) begin
      exp_q.push_back(expv);
      tag_q.push_back(tag);
    end
    repeat (k * cur_n) strobe(pat);
    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R5 result count", k - exp_q.size(), k);
    exp_q.delete();
    tag_q.delete();
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o) begin
        check(!prev_valid, "R9 single-cycle valid", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected valid", 1, 0);
        end else begin
          logic [14:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(sample_o == e, t, sample_o, e);
          check(word_o == {1'b0, e}, "R7 transfer word", word_o, {1'b0, e});
          check(stb_cnt == (4 + out_idx) * cur_n, "R5 result spacing",
                stb_cnt, (4 + out_idx) * cur_n);
          out_idx++;
        end
      end
      prev_valid <= valid_o;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(sample_o == 15'd0, "R1 reset sample", sample_o, 0);
    check(word_o == 16'd0, "R1 reset word", word_o, 0);
    check(valid_o == 1'b0, "R1 reset valid", valid_o, 0);
    rst_ni = 1'b1;
    run_case(2'd0, 4'b1111, 15'h3FFF, "R2 all ones", 3);
    repeat (13) strobe(4'b0101);  // partial period before the next change
    run_case(2'd1, 4'b0000, 15'h4000, "R2 all zeros", 3);
    run_case(2'd2, 4'b0101, 15'h0000, "R4 alternating", 3);
    run_case(2'd3, 4'b0111, 15'h2000, "R3 R8 three-quarter density", 3);
    repeat (13) strobe(4'b1111);
    run_case(2'd0, 4'b0001, 15'h6000, "R3 quarter density", 3);
    run_case(2'd1, 4'b0111, 15'h2000, "R3 three-quarter density", 3);
    run_case(2'd2, 4'b0001, 15'h6000, "R3 R6 quarter density", 3);
    run_case(2'd3, 4'b1111, 15'h3FFF, "R2 all ones N=256", 3);
    repeat (5) @(negedge clk_i);
    check(sample_o == 15'h3FFF && valid_o == 1'b0, "R9 sample held",
          sample_o, 15'h3FFF);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule